// File: doc/BRIEF.md
# Warp Memory Access Coalescer

The coalescer takes one memory instruction issued by a warp and turns the per-thread accesses into the smallest set of aligned memory transactions. Each thread supplies a byte address and an access size, and an active mask selects which threads take part. The block groups the accesses by 128-byte segment and emits one transaction per cycle over a valid/ready handshake. Each transaction carries an aligned base address, a size of 32, 64 or 128 bytes, and the mask of the threads it serves.

Three mode inputs, captured with the instruction, shape the result. Half-warp grouping coalesces the two 16-thread halves on their own, lower half first. Cached operation in full-warp grouping issues whole 128-byte segments only. Atomic operation keeps threads that target the same address apart, so each read-modify-write reaches memory once per thread. A done strobe marks the last transaction of an instruction. A new instruction is taken only once the previous one has fully drained.

Top module: `warp_coalescer`

## Requirements
- R1: Active threads reading consecutive 4-byte words that lie inside one aligned 128-byte segment produce exactly one transaction of 128 bytes, provided the words span both 64-byte halves of the segment.
- R2: When the active accesses touch two different 128-byte segments, exactly two transactions are produced, one for each segment.
- R3: With half_warp_i set, threads 0 to 15 and threads 16 to 31 are coalesced separately. No transaction mixes threads of both halves, and every transaction of the lower half comes before any transaction of the upper half.
- R4: txn_size_o codes 0, 1 and 2 mean 32, 64 and 128 bytes, and txn_addr_o is aligned to that size. With half_warp_i clear and cached_i set, every transaction is 128 bytes at a segment base.
- R5: In the modes that allow variable sizes, a transaction shrinks to the aligned 32-byte piece of its segment when all touched bytes fit in that piece. Otherwise it shrinks to the aligned 64-byte half when they fit there. Otherwise it is 128 bytes.
- R6: With atomic_i set, no transaction holds two threads with the same address. Within a segment, each transaction takes the lowest-numbered remaining thread for each distinct address.
- R7: Threads whose mask bit is 0 do not affect any transaction. An all-zero mask produces no transaction, and done_o is raised in the cycle the instruction is accepted.
- R8: Within a group, transactions come out in ascending segment order. done_o is high exactly when the last transaction of the instruction is presented.
- R9: While txn_ready_i is low, a presented transaction holds its address, size and mask. req_ready_o stays low from acceptance until the last transaction has been taken.
- R10: Per-thread size code k means an access of 2^k bytes, naturally aligned, and all of its bytes count when the transaction size is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Instruction presented |
| req_ready_o | output | 1 | Block can take an instruction |
| req_addr_i | input | NUM_THREADS*ADDR_W | Byte address per thread, thread 0 in the low bits |
| req_size_i | input | 2*NUM_THREADS | Access size code per thread (2^k bytes) |
| req_mask_i | input | NUM_THREADS | Active thread mask |
| half_warp_i | input | 1 | Coalesce each half of the warp separately |
| cached_i | input | 1 | Cached operation |
| atomic_i | input | 1 | Atomic operation |
| txn_valid_o | output | 1 | Transaction presented |
| txn_ready_i | input | 1 | Transaction taken |
| txn_addr_o | output | ADDR_W | Aligned transaction base address |
| txn_size_o | output | 2 | 0: 32 B, 1: 64 B, 2: 128 B |
| txn_mask_o | output | NUM_THREADS | Threads served by the transaction |
| done_o | output | 1 | Last transaction of the instruction, or empty instruction accepted |

## Verification
A sweep runs thread strides of 0 to 256 bytes against all eight combinations of grouping, caching and atomic mode, with full and sparse masks. The strides separate the cases where all threads hit one word, fill a 32-byte or 64-byte piece, cover a whole segment, or scatter across one segment per thread. An unaligned base makes the shrink rule pick different pieces, and stride 0 with atomic mode set yields one transaction per thread. Directed cases cover descending addresses, which show that output order is set by address and not by thread index. They also cover 8-byte accesses, inactive threads parked at far-away addresses, an empty mask, and duplicate atomic addresses. Part of the sweep runs with periodic backpressure to exercise the hold behaviour.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int unsigned SEG_LG = 7;  // 128-byte segment

  typedef enum logic [1:0] {
    TXN_32  = 2'd0,
    TXN_64  = 2'd1,
    TXN_128 = 2'd2
  } txn_size_e;
endpackage

// File: rtl/coal_seg_pick.sv
module coal_seg_pick #(
  parameter int unsigned NUM_THREADS = 32,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SEG_LG      = 7
) (
  input  logic [NUM_THREADS*ADDR_W-1:0] addr_i,
  input  logic [NUM_THREADS-1:0]        cand_i,
  output logic                          found_o,
  output logic [ADDR_W-SEG_LG-1:0]      seg_o,
  output logic [NUM_THREADS-1:0]        seg_mask_o
);
  localparam int unsigned SEG_W = ADDR_W - SEG_LG;

  logic [SEG_W-1:0] seg [NUM_THREADS];

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_seg
    assign seg[g] = addr_i[g*ADDR_W+SEG_LG +: SEG_W];
    assign seg_mask_o[g] = cand_i[g] && (seg[g] == seg_o);
  end

  always_comb begin
    found_o = 1'b0;
    seg_o   = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (cand_i[i] && (!found_o || seg[i] < seg_o)) begin
        found_o = 1'b1;
        seg_o   = seg[i];
      end
    end
  end
endmodule

// File: rtl/coal_atomic_filter.sv
module coal_atomic_filter #(
  parameter int unsigned NUM_THREADS = 32,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic [NUM_THREADS*ADDR_W-1:0] addr_i,
  input  logic [NUM_THREADS-1:0]        seg_mask_i,
  input  logic                          atomic_i,
  output logic [NUM_THREADS-1:0]        sel_o
);
  // keep only the first thread per distinct address when atomic
  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) begin
      logic dup;
      dup = 1'b0;
      for (int j = 0; j < NUM_THREADS; j++) begin
        if (j < i && seg_mask_i[j] &&
            addr_i[j*ADDR_W +: ADDR_W] == addr_i[i*ADDR_W +: ADDR_W])
          dup = 1'b1;
      end
      sel_o[i] = seg_mask_i[i] && !(atomic_i && dup);
    end
  end
endmodule

// File: rtl/coal_extent.sv
module coal_extent
  import coal_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 32,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SEG_LG      = 7
) (
  input  logic [NUM_THREADS*ADDR_W-1:0] addr_i,
  input  logic [2*NUM_THREADS-1:0]      size_i,
  input  logic [NUM_THREADS-1:0]        sel_i,
  input  logic                          force_full_i,
  output logic [SEG_LG-1:0]             base_off_o,
  output txn_size_e                     size_o
);
  localparam int unsigned OFF_W = SEG_LG + 1;

  logic [OFF_W-1:0] lo, hi;

  always_comb begin
    lo = '1;
    hi = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      logic [OFF_W-1:0] first_b, last_b;
      first_b = {1'b0, addr_i[i*ADDR_W +: SEG_LG]};
      last_b  = first_b + (OFF_W'(1) << size_i[2*i +: 2]) - OFF_W'(1);
      if (sel_i[i]) begin
        if (first_b < lo) lo = first_b;
        if (last_b > hi)  hi = last_b;
      end
    end
  end

  always_comb begin
    if (force_full_i || lo[SEG_LG-1] != hi[SEG_LG-1]) begin
      size_o     = TXN_128;
      base_off_o = '0;
    end else if (lo[SEG_LG-2] != hi[SEG_LG-2]) begin
      size_o     = TXN_64;
      base_off_o = {lo[SEG_LG-1], {(SEG_LG-1){1'b0}}};
    end else begin
      size_o     = TXN_32;
      base_off_o = {lo[SEG_LG-1:SEG_LG-2], {(SEG_LG-2){1'b0}}};
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 32,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [NUM_THREADS*ADDR_W-1:0] req_addr_i,
  input  logic [2*NUM_THREADS-1:0]      req_size_i,
  input  logic [NUM_THREADS-1:0]        req_mask_i,
  input  logic                          half_warp_i,
  input  logic                          cached_i,
  input  logic                          atomic_i,
  output logic                          txn_valid_o,
  input  logic                          txn_ready_i,
  output logic [ADDR_W-1:0]             txn_addr_o,
  output logic [1:0]                    txn_size_o,
  output logic [NUM_THREADS-1:0]        txn_mask_o,
  output logic                          done_o
);
  localparam int unsigned HALF  = NUM_THREADS / 2;
  localparam int unsigned SEG_W = ADDR_W - SEG_LG;
  localparam logic [NUM_THREADS-1:0] LO_M =
    {{(NUM_THREADS-HALF){1'b0}}, {HALF{1'b1}}};

  logic                          busy_q;
  logic [NUM_THREADS-1:0]        pend_q;
  logic [NUM_THREADS*ADDR_W-1:0] addr_q;
  logic [2*NUM_THREADS-1:0]      size_q;
  logic                          half_q, cached_q, atomic_q;

  logic [NUM_THREADS-1:0] cand, seg_mask, sel, remain;
  logic                   found;
  logic [SEG_W-1:0]       seg;
  logic [SEG_LG-1:0]      base_off;
  txn_size_e              tsize;
  logic                   last, take, accept;

  always_comb begin
    if (!half_q)                    cand = pend_q;
    else if ((pend_q & LO_M) != '0) cand = pend_q & LO_M;
    else                            cand = pend_q & ~LO_M;
  end

  coal_seg_pick #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W), .SEG_LG(SEG_LG)) u_pick (
    .addr_i    (addr_q),
    .cand_i    (cand),
    .found_o   (found),
    .seg_o     (seg),
    .seg_mask_o(seg_mask)
  );

  coal_atomic_filter #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W)) u_atom (
    .addr_i    (addr_q),
    .seg_mask_i(seg_mask),
    .atomic_i  (atomic_q),
    .sel_o     (sel)
  );

  coal_extent #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W), .SEG_LG(SEG_LG)) u_ext (
    .addr_i      (addr_q),
    .size_i      (size_q),
    .sel_i       (sel),
    .force_full_i(cached_q && !half_q),
    .base_off_o  (base_off),
    .size_o      (tsize)
  );

  assign remain      = pend_q & ~sel;
  assign last        = (remain == '0);
  assign txn_valid_o = busy_q && found;
  assign txn_addr_o  = {seg, base_off};
  assign txn_size_o  = tsize;
  assign txn_mask_o  = sel;
  assign req_ready_o = !busy_q;
  assign take        = txn_valid_o && txn_ready_i;
  assign accept      = req_valid_i && req_ready_o;
  assign done_o      = (txn_valid_o && last) || (accept && req_mask_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      pend_q   <= '0;
      addr_q   <= '0;
      size_q   <= '0;
      half_q   <= 1'b0;
      cached_q <= 1'b0;
      atomic_q <= 1'b0;
    end else if (accept) begin
      busy_q   <= (req_mask_i != '0);
      pend_q   <= req_mask_i;
      addr_q   <= req_addr_i;
      size_q   <= req_size_i;
      half_q   <= half_warp_i;
      cached_q <= cached_i;
      atomic_q <= atomic_i;
    end else if (take) begin
      pend_q <= remain;
      if (last) busy_q <= 1'b0;
    end
  end

  // checking-only state
  logic             seen_q;
  logic [SEG_W-1:0] prev_seg_q;
  logic             dup_in_txn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      prev_seg_q <= '0;
    end else if (accept) begin
      seen_q <= 1'b0;
    end else if (take) begin
      seen_q     <= 1'b1;
      prev_seg_q <= txn_addr_o[ADDR_W-1:SEG_LG];
    end
  end

  always_comb begin
    dup_in_txn = 1'b0;
    for (int i = 0; i < NUM_THREADS; i++)
      for (int j = 0; j < NUM_THREADS; j++)
        if (i < j && txn_mask_o[i] && txn_mask_o[j] &&
            req_addr_q_eq(i, j)) dup_in_txn = 1'b1;
  end

  function automatic logic req_addr_q_eq(int a, int b);
    return addr_q[a*ADDR_W +: ADDR_W] == addr_q[b*ADDR_W +: ADDR_W];
  endfunction

  AST_TXN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_addr_o) &&
    $stable(txn_size_o) && $stable(txn_mask_o));  // R9
  AST_MASK_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> txn_mask_o != '0);  // R7
  AST_FULL_CACHED_128: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && cached_q && !half_q |-> txn_size_o == TXN_128);  // R4
  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> (txn_addr_o[4:0] == '0) &&
    (txn_size_o == TXN_32 || txn_addr_o[5] == 1'b0) &&
    (txn_size_o != TXN_128 || txn_addr_o[6] == 1'b0));  // R4
  AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && seen_q && !half_q |-> txn_addr_o[ADDR_W-1:SEG_LG] >= prev_seg_q);  // R8
  AST_ATOMIC_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && atomic_q |-> !dup_in_txn);  // R6
  AST_HALF_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && half_q |-> (txn_mask_o & LO_M) == '0 || (txn_mask_o & ~LO_M) == '0);  // R3
endmodule

// File: tb/warp_coalescer_tb_top.sv
`timescale 1ns/1ps
module warp_coalescer_tb_top;
  localparam int N  = 32;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [N*AW-1:0] req_addr = '0;
  logic [2*N-1:0]  req_size = '0;
  logic [N-1:0]    req_mask = '0;
  logic            half_w = 1'b0, cached = 1'b0, atomic = 1'b0;
  logic            txn_valid, txn_ready, done;
  logic [AW-1:0]   txn_addr;
  logic [1:0]      txn_size;
  logic [N-1:0]    txn_mask;

  warp_coalescer #(.NUM_THREADS(N), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_mask_i(req_mask),
    .half_warp_i(half_w), .cached_i(cached), .atomic_i(atomic),
    .txn_valid_o(txn_valid), .txn_ready_i(txn_ready),
    .txn_addr_o(txn_addr), .txn_size_o(txn_size), .txn_mask_o(txn_mask),
    .done_o(done)
  );

  int checks = 0, errors = 0;
  int cyc = 0, done_cnt = 0;
  bit bp_en = 0;

  logic [31:0] ta [N];
  logic [1:0]  ts [N];

  logic [31:0] got_addr [64]; logic [1:0] got_size [64];
  logic [N-1:0] got_mask [64]; bit got_done [64]; int got_n = 0;
  logic [31:0] exp_addr [64]; logic [1:0] exp_size [64];
  logic [N-1:0] exp_mask [64]; int exp_n = 0;

  bit hold_pend = 0;
  logic [31:0] h_addr; logic [1:0] h_size; logic [N-1:0] h_mask;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial txn_ready = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      txn_ready = bp_en ? (cyc % 3 != 0) : 1'b1;
      if (hold_pend && txn_valid)
        chk(txn_addr == h_addr && txn_size == h_size && txn_mask == h_mask,
            "R9", "held txn changed", longint'(txn_addr), longint'(h_addr));
      hold_pend = txn_valid && !txn_ready;
      h_addr = txn_addr; h_size = txn_size; h_mask = txn_mask;
      if (txn_valid && txn_ready && got_n < 64) begin
        if (req_ready) chk(0, "R9", "req_ready while busy", 1, 0);
        got_addr[got_n] = txn_addr; got_size[got_n] = txn_size;
        got_mask[got_n] = txn_mask; got_done[got_n] = done;
        got_n++;
      end
      if (done && (!txn_valid || txn_ready)) done_cnt++;
    end
  end

  // reference model, written from the requirements
  task automatic model();
    exp_n = 0;
    for (int g = 0; g < (half_w ? 2 : 1); g++) begin
      logic [N-1:0] pend;
      pend = '0;
      for (int i = 0; i < N; i++)
        if (req_mask[i] && (!half_w || (i / 16) == g)) pend[i] = 1'b1;
      while (pend != '0) begin
        logic [24:0] smin; bit have; logic [N-1:0] tm; logic [3:0] q;
        have = 0; smin = '0; tm = '0; q = '0;
        for (int i = 0; i < N; i++)
          if (pend[i] && (!have || ta[i][31:7] < smin)) begin have = 1; smin = ta[i][31:7]; end
        for (int i = 0; i < N; i++) begin
          bit skip; skip = 0;
          if (pend[i] && ta[i][31:7] == smin) begin
            if (atomic)
              for (int k = 0; k < i; k++)
                if (pend[k] && ta[k] == ta[i]) skip = 1;
            if (!skip) begin
              tm[i] = 1'b1;
              for (int b = 0; b < (1 << ts[i]); b++) q[(ta[i][6:0] + b) / 32] = 1'b1;
            end
          end
        end
        exp_mask[exp_n] = tm;
        if (cached && !half_w)  begin exp_size[exp_n] = 2; exp_addr[exp_n] = {smin, 7'd0}; end
        else if ($countones(q) == 1) begin
          exp_size[exp_n] = 0;
          exp_addr[exp_n] = {smin, 7'd0} + (q[1] ? 32 : q[2] ? 64 : q[3] ? 96 : 0);
        end
        else if (q[3:2] == 0) begin exp_size[exp_n] = 1; exp_addr[exp_n] = {smin, 7'd0}; end
        else if (q[1:0] == 0) begin exp_size[exp_n] = 1; exp_addr[exp_n] = {smin, 7'd64}; end
        else begin exp_size[exp_n] = 2; exp_addr[exp_n] = {smin, 7'd0}; end
        exp_n++;
        pend &= ~tm;
      end
    end
  endtask

  task automatic run(logic [N-1:0] m, bit h, bit c, bit a, string req);
    int d0, to;
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    for (int i = 0; i < N; i++) begin
      req_addr[i*AW +: AW] = ta[i]; req_size[2*i +: 2] = ts[i];
    end
    req_mask = m; half_w = h; cached = c; atomic = a;
    model();
    got_n = 0; d0 = done_cnt;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    to = 0;
    while (done_cnt == d0 && to < 400) begin @(posedge clk); #1; to++; end
    @(negedge clk);
    chk(got_n == exp_n, req, "txn count", got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      chk(got_addr[k] == exp_addr[k], req, "txn addr", longint'(got_addr[k]), longint'(exp_addr[k]));
      chk(got_size[k] == exp_size[k], req, "txn size", longint'(got_size[k]), longint'(exp_size[k]));
      chk(got_mask[k] == exp_mask[k], req, "txn mask", longint'(got_mask[k]), longint'(exp_mask[k]));
      chk(got_done[k] == (k == exp_n - 1), "R8", "done placement", got_done[k], k == exp_n - 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int strides [8] = '{0, 4, 8, 16, 32, 64, 128, 256};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "reset req_ready", req_ready, 1);
    chk(txn_valid == 1'b0, "R8", "reset txn_valid", txn_valid, 0);

    // R1: 32 consecutive words in one segment
    for (int i = 0; i < N; i++) begin ta[i] = 32'h1000 + i*4; ts[i] = 2; end
    run('1, 0, 0, 0, "R1");
    chk(got_n == 1 && got_size[0] == 2, "R1", "single 128B", got_n, 1);

    // R2/R5: straddling two segments from offset 64
    for (int i = 0; i < N; i++) begin ta[i] = 32'h2040 + i*4; ts[i] = 2; end
    run('1, 0, 0, 0, "R2");
    chk(got_n == 2 && got_size[0] == 1 && got_size[1] == 1, "R5", "two 64B pieces", got_n, 2);

    // R3: half-warp split
    for (int i = 0; i < N; i++) begin ta[i] = 32'h3000 + i*4; ts[i] = 2; end
    run('1, 1, 1, 0, "R3");
    chk(got_n == 2 && got_mask[0] == 32'h0000_FFFF, "R3", "lower half first", longint'(got_mask[0]), 32'hFFFF);

    // R4: cached full warp, narrow footprint still 128B
    for (int i = 0; i < N; i++) begin ta[i] = 32'h4020 + (i % 8)*4; ts[i] = 2; end
    run('1, 0, 1, 0, "R4");
    chk(got_n == 1 && got_size[0] == 2 && got_addr[0] == 32'h4000, "R4", "cached 128B", longint'(got_addr[0]), 32'h4000);

    // R5: same word, uncached -> 32B
    for (int i = 0; i < N; i++) begin ta[i] = 32'h5064; ts[i] = 2; end
    run('1, 0, 0, 0, "R5");
    chk(got_n == 1 && got_size[0] == 0 && got_addr[0] == 32'h5060, "R5", "shrink to 32B", longint'(got_addr[0]), 32'h5060);

    // R6: atomic, four distinct addresses repeated
    for (int i = 0; i < N; i++) begin ta[i] = 32'h6000 + (i % 4)*4; ts[i] = 2; end
    run('1, 0, 0, 1, "R6");
    chk(got_n == 8 && got_mask[0] == 32'hF, "R6", "atomic split", got_n, 8);

    // R7: inactive threads at far addresses
    for (int i = 0; i < N; i++) begin ta[i] = (i < 16) ? 32'h7000 + i*4 : 32'hDEAD_0000 + i*512; ts[i] = 2; end
    run(32'h0000_FFFF, 0, 0, 0, "R7");
    chk(got_n == 1 && got_size[0] == 1, "R7", "inactive ignored", got_n, 1);
    run('0, 0, 0, 0, "R7");
    chk(got_n == 0, "R7", "empty warp no txn", got_n, 0);

    // R8: descending addresses come out ascending
    for (int i = 0; i < N; i++) begin ta[i] = 32'h9000 + (31 - i)*8; ts[i] = 2; end
    run('1, 0, 0, 0, "R8");
    chk(got_n == 2 && got_addr[0] == 32'h9000, "R8", "ascending order", longint'(got_addr[0]), 32'h9000);

    // R10: 8-byte accesses
    for (int i = 0; i < N; i++) begin ta[i] = 32'hA000 + i*8; ts[i] = 3; end
    run('1, 0, 0, 0, "R10");
    for (int i = 0; i < N; i++) begin ta[i] = 32'hA018; ts[i] = 3; end
    run(32'h1, 0, 0, 0, "R10");
    chk(got_n == 1 && got_size[0] == 0, "R10", "8B in one 32B piece", got_n, 1);

    // sweep, with backpressure
    bp_en = 1;
    foreach (strides[si]) begin
      for (int md = 0; md < 8; md++) begin
        for (int i = 0; i < N; i++) begin ta[i] = 32'h10028 + i*strides[si]; ts[i] = 2; end
        run(si[0] ? 32'hF0F0_5A3C : '1, md[0], md[1], md[2], "R5");
      end
    end
    bp_en = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule